// File: doc/BRIEF.md
# Voting Glitch Filter with Relock Reset Pulse

This block sits between a supply comparator, whose output has already been brought into the clock domain, and the reset input of a PLL or VCO domain. The comparator output is sampled on a slow tick, and the last M samples are held in a sliding window. A fault is declared only when at least K of those samples read bad. A short, isolated spike therefore cannot disturb the clock tree, while a burst of bad samples within the window is acted on.

A declared fault starts a reset pulse that is long enough for the downstream PLL to lock again. Its width is the PLL minimum lock time plus one fifth of it, and it never falls below a fixed floor set by a parameter. The reset output is a single register. It falls and rises on one clock edge each, with no gradual tail. A fault declared while the pulse is already running starts the full width again, so release comes only after the rail has stayed clean for a whole pulse. After power-on reset the output is held low for one full pulse width before it is first released.

K, M, the sample interval and the lock time are configuration inputs. The analog thresholds, hysteresis and the output pad are outside this block.

Top module: `rail_vote_reset`

## Requirements
- R1: While `rst_n` is low, `rst_out_n_o` is low. After `rst_n` is released, the output stays low and rises on the W-th clock edge, where W is the pulse width defined in R5.
- R2: The rail input is sampled only on tick edges. Tick edges are edge number `cfg_div_i`, 2·`cfg_div_i`, and so on, counted from the release of reset (a value of 0 is treated as 1). In `rail_bad_i`, 1 means bad.
- R3: The window holds the last M samples. A trip is declared on a tick edge when at least K of those samples are bad. A sample pattern with fewer than K bad samples in every group of M consecutive samples never trips.
- R4: A configured K of 0, or a K greater than M, is treated as K = M. A configured M of 0, or an M greater than MAX_M, is treated as MAX_M.
- R5: The pulse width is W = max(L + floor(L/5), FLOOR_CYC) clock cycles, where L is `cfg_lock_i`.
- R6: The output falls on the clock edge after the tick edge that trips. It stays low for exactly W clock edges after the last trip and then rises on a single edge.
- R7: A trip during an active pulse reloads the full width, so release moves to W edges after the new trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_bad_i | input | 1 | Synchronized comparator output, 1 = rail bad |
| cfg_k_i | input | CW | Bad-sample count that trips |
| cfg_m_i | input | CW | Window length in samples |
| cfg_div_i | input | DW | Clock cycles between samples |
| cfg_lock_i | input | PW | PLL minimum lock time in clock cycles |
| rst_out_n_o | output | 1 | Active-low reset to the PLL domain |

## Verification
Latencies are counted from the release of reset:
- A sample is taken on edge n·div.
- A trip raises the internal flag on that same tick edge.
- The output falls one edge later.
- The output rises W edges after the last trip, or W edges after reset is released.

The bench keeps its own edge counter from the release of reset. It places each rail value just before a known tick edge and reads the output at the falling clock edge after the edge on which each result is due. For every transition it checks both the cycle before the change and the cycle of the change. Quiet periods are watched on every cycle.

// File: rtl/rvr_pkg.sv
// Shared helpers for the voting reset filter.
// Assumes: callers pass configuration values already widened to 32 bits.
package rvr_pkg;

    // Window length after clamping into 1..max_len.
    function automatic int unsigned clamp_len(input int unsigned len, input int unsigned max_len);
        return (len == 0 || len > max_len) ? max_len : len;
    endfunction

    // Trip threshold after clamping: 0 or above the window length selects the window length.
    function automatic int unsigned clamp_thr(input int unsigned thr, input int unsigned len);
        return (thr == 0 || thr > len) ? len : thr;
    endfunction

endpackage

// File: rtl/rvr_tick_gen.sv
// Sample tick generator: pulses tick_o for one cycle every cfg_div_i clocks.
// Assumes: cfg_div_i is steady during operation; 0 is treated as 1.
module rvr_tick_gen #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cfg_div_i,
    output logic          tick_o
);
    logic [DW-1:0] div_eff;
    logic [DW-1:0] cnt_q;

    // Effective interval, never zero.
    always_comb div_eff = (cfg_div_i == '0) ? DW'(1) : cfg_div_i;

    // Tick on the last count of each interval.
    always_comb tick_o = (cnt_q >= div_eff - DW'(1));

    // Interval counter, wraps on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + DW'(1);
    end

    // R2: counter stays inside the interval.
    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < div_eff);

    // R2: ticks are spaced apart when the interval exceeds one clock.
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_eff > DW'(1)) |=> !tick_o);
endmodule

// File: rtl/rvr_vote_window.sv
// Sliding sample window with a population count, compared against K on each tick.
// Assumes: bad_i is already synchronous to clk; MAX_M is at least 2.
module rvr_vote_window #(
    parameter int MAX_M = 8,
    parameter int CW    = $clog2(MAX_M + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          bad_i,
    input  logic [CW-1:0] cfg_k_i,
    input  logic [CW-1:0] cfg_m_i,
    output logic          trip_o
);
    logic [MAX_M-1:0] hist_q;
    logic [MAX_M-1:0] hist_nxt;
    logic [MAX_M-1:0] mask;
    int unsigned      m_eff;
    int unsigned      k_eff;
    int unsigned      ones_nxt;
    int unsigned      ones_now;

    // Clamped window length and threshold (R4).
    always_comb begin
        m_eff = rvr_pkg::clamp_len(32'(cfg_m_i), MAX_M);
        k_eff = rvr_pkg::clamp_thr(32'(cfg_k_i), m_eff);
    end

    // One mask bit per window slot, set for the newest m_eff slots.
    for (genvar g = 0; g < MAX_M; g++) begin : g_mask
        assign mask[g] = (32'(g) < m_eff);
    end

    // Shifted history with the new sample in bit 0.
    always_comb hist_nxt = {hist_q[MAX_M-2:0], bad_i};

    // Bad-sample counts of the current and the next window.
    always_comb begin
        ones_nxt = 0;
        ones_now = 0;
        for (int i = 0; i < MAX_M; i++) begin
            ones_nxt += 32'(hist_nxt[i] & mask[i]);
            ones_now += 32'(hist_q[i] & mask[i]);
        end
    end

    // Shift on tick; raise a one-cycle trip flag when the count reaches K (R3).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            trip_o <= 1'b0;
        end else begin
            trip_o <= 1'b0;
            if (tick_i) begin
                hist_q <= hist_nxt;
                trip_o <= (ones_nxt >= k_eff);
            end
        end
    end

    // R2: a trip only follows a sample tick.
    assert_trip_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !trip_o);

    // R3: a clean window plus a good sample cannot trip.
    assert_clean_no_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !bad_i && ones_now == 0) |=> !trip_o);

    // R4: the clamped threshold is always reachable and nonzero.
    assert_thr_clamped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (k_eff >= 1) && (k_eff <= m_eff) && (m_eff <= MAX_M));
endmodule

// File: rtl/rvr_oneshot.sv
// Relock pulse timer: holds the reset low for W cycles after the last trip.
// Assumes: FLOOR_CYC >= 1 and fits in PW+1 bits; cfg_lock_i is steady around trips.
module rvr_oneshot #(
    parameter int PW        = 20,
    parameter int FLOOR_CYC = 125000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trip_i,
    input  logic [PW-1:0] cfg_lock_i,
    output logic          rst_out_n_o
);
    localparam int RW = PW + 1;
    localparam logic [RW-1:0] FLOOR_W = RW'(FLOOR_CYC);

    logic [PW-1:0] fifth;
    logic [RW-1:0] ext;
    logic [RW-1:0] width;
    logic [RW-1:0] rem_q;

    // Lock time plus a fifth, then raised to the floor (R5).
    always_comb begin
        fifth = cfg_lock_i / PW'(5);
        ext   = {1'b0, cfg_lock_i} + {1'b0, fifth};
        width = (ext > FLOOR_W) ? ext : FLOOR_W;
    end

    // Load on reset or trip, count down, release on the last count (R1, R6, R7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q       <= width;
            rst_out_n_o <= 1'b0;
        end else if (trip_i) begin
            rem_q       <= width;
            rst_out_n_o <= 1'b0;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - RW'(1);
            if (rem_q == RW'(1)) rst_out_n_o <= 1'b1;
        end
    end

    // R7: a trip reloads the full width and holds the output low.
    assert_trip_reloads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |=> (!rst_out_n_o && rem_q == $past(width)));

    // R6: release only from the final count with no trip pending.
    assert_release_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n_o) |-> ($past(rem_q) == RW'(1) && !$past(trip_i)));

    // R6: an expired timer means the output is released.
    assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q == '0) |-> rst_out_n_o);
endmodule

// File: rtl/rail_vote_reset.sv
// Top: sample tick, K-of-M vote window and relock pulse timer in series.
// Assumes: rail_bad_i is synchronized; configuration is held steady in operation.
module rail_vote_reset #(
    parameter int MAX_M     = 8,
    parameter int DW        = 16,
    parameter int PW        = 20,
    parameter int FLOOR_CYC = 125000,
    parameter int CW        = $clog2(MAX_M + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rail_bad_i,
    input  logic [CW-1:0] cfg_k_i,
    input  logic [CW-1:0] cfg_m_i,
    input  logic [DW-1:0] cfg_div_i,
    input  logic [PW-1:0] cfg_lock_i,
    output logic          rst_out_n_o
);
    logic tick_w;
    logic trip_w;

    rvr_tick_gen #(.DW(DW)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_div_i (cfg_div_i),
        .tick_o    (tick_w)
    );

    rvr_vote_window #(.MAX_M(MAX_M), .CW(CW)) u_vote (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_w),
        .bad_i   (rail_bad_i),
        .cfg_k_i (cfg_k_i),
        .cfg_m_i (cfg_m_i),
        .trip_o  (trip_w)
    );

    rvr_oneshot #(.PW(PW), .FLOOR_CYC(FLOOR_CYC)) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip_i      (trip_w),
        .cfg_lock_i  (cfg_lock_i),
        .rst_out_n_o (rst_out_n_o)
    );

    // R6: every falling edge of the output is caused by a trip one cycle earlier.
    assert_fall_follows_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n_o) |-> $past(trip_w));
endmodule

// File: tb/sim_rail_vote_reset.sv
// Directed bench for rail_vote_reset; one task per scenario.
module sim_rail_vote_reset;
    localparam int MAX_M = 8;
    localparam int DW    = 16;
    localparam int PW    = 20;
    localparam int FLOOR = 40;
    localparam int CW    = $clog2(MAX_M + 1);
    localparam int DIV   = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rail_bad;
    logic [CW-1:0] cfg_k;
    logic [CW-1:0] cfg_m;
    logic [DW-1:0] cfg_div;
    logic [PW-1:0] cfg_lock;
    logic          rst_out_n;

    int e = 0;
    int n_chk = 0;
    int n_fail = 0;
    int low_seen = 0;
    logic watch = 1'b0;

    always #4 clk = ~clk;

    rail_vote_reset #(.MAX_M(MAX_M), .DW(DW), .PW(PW), .FLOOR_CYC(FLOOR)) u0 (
        .clk(clk), .rst_n(rst_n), .rail_bad_i(rail_bad), .cfg_k_i(cfg_k),
        .cfg_m_i(cfg_m), .cfg_div_i(cfg_div), .cfg_lock_i(cfg_lock),
        .rst_out_n_o(rst_out_n)
    );

    // Edge counter since reset release.
    always @(posedge clk) begin
        if (!rst_n) e <= 0;
        else        e <= e + 1;
    end

    // Count cycles with the output low while a quiet period is watched.
    always @(negedge clk) begin
        if (watch && rst_out_n !== 1'b1) low_seen++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, e);
        end
    endtask

    task automatic wait_until(input int n);
        while (e < n) @(negedge clk);
    endtask

    // Place a rail value just before the next tick edge; return that edge index.
    task automatic put_sample(input logic b, output int t);
        while (((e + 1) % DIV) != 0) @(negedge clk);
        rail_bad = b;
        @(negedge clk);
        t = e;
    endtask

    function automatic int width_of(input int l);
        return ((l + l / 5) > FLOOR) ? (l + l / 5) : FLOOR;
    endfunction

    // Clear the window with good samples and wait for release.
    task automatic flush();
        int t;
        for (int i = 0; i < MAX_M; i++) put_sample(1'b0, t);
        while (rst_out_n !== 1'b1) @(negedge clk);
    endtask

    task automatic t_power_on();
        int w;
        w = width_of(int'(cfg_lock));
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 low in reset", int'(rst_out_n), 0);
        rst_n = 1'b1;
        wait_until(w - 1);
        chk("R1 low before width", int'(rst_out_n), 0);
        wait_until(w);
        chk("R1 release at width", int'(rst_out_n), 1);
    endtask

    task automatic t_sparse();
        int t;
        cfg_k = CW'(2); cfg_m = CW'(3);
        flush();
        low_seen = 0; watch = 1'b1;
        for (int i = 0; i < 9; i++) put_sample((i % 3) == 0, t);
        repeat (8) @(negedge clk);
        watch = 1'b0;
        chk("R3 sparse spikes no trip", low_seen, 0);
    endtask

    task automatic t_cluster();
        int t, tl, w;
        cfg_k = CW'(2); cfg_m = CW'(3); cfg_lock = PW'(30);
        w = width_of(30);
        flush();
        put_sample(1'b1, t);
        put_sample(1'b1, t);
        chk("R6 high on trip tick", int'(rst_out_n), 1);
        @(negedge clk);
        chk("R6 falls next edge", int'(rst_out_n), 0);
        put_sample(1'b0, tl);   // window still holds two bad: trips again
        put_sample(1'b0, t);
        wait_until(tl + w);
        chk("R5 floor width low", int'(rst_out_n), 0);
        wait_until(tl + w + 1);
        chk("R5 floor width release", int'(rst_out_n), 1);
    endtask

    task automatic t_retrigger();
        int t, tl, t2, w;
        cfg_k = CW'(2); cfg_m = CW'(3); cfg_lock = PW'(30);
        w = width_of(30);
        flush();
        put_sample(1'b1, t);
        put_sample(1'b1, t);
        put_sample(1'b0, tl);
        put_sample(1'b0, t);
        wait_until(tl + 28);
        put_sample(1'b1, t);
        put_sample(1'b1, t);
        put_sample(1'b0, t2);
        put_sample(1'b0, t);
        wait_until(tl + w + 1);
        chk("R7 retrigger holds past first end", int'(rst_out_n), 0);
        wait_until(t2 + w);
        chk("R7 low until new end", int'(rst_out_n), 0);
        wait_until(t2 + w + 1);
        chk("R7 release after new width", int'(rst_out_n), 1);
    endtask

    task automatic t_three_of_five();
        int t, w;
        logic [9:0] pat;
        cfg_k = CW'(3); cfg_m = CW'(5); cfg_lock = PW'(100);
        w = width_of(100);
        pat = 10'b1010100101;   // bit 0 first: 1,0,1,0,0,1,0,1,0,1
        flush();
        low_seen = 0; watch = 1'b1;
        for (int i = 0; i < 10; i++) put_sample(pat[i], t);
        watch = 1'b0;
        chk("R3 two of five no trip", low_seen, 0);
        chk("R6 high on 3-of-5 tick", int'(rst_out_n), 1);
        @(negedge clk);
        chk("R3 three of five trips", int'(rst_out_n), 0);
        put_sample(1'b0, t);
        put_sample(1'b0, t);
        wait_until((t - 2 * DIV) + w);
        chk("R5 lock plus fifth low", int'(rst_out_n), 0);
        wait_until((t - 2 * DIV) + w + 1);
        chk("R5 lock plus fifth release", int'(rst_out_n), 1);
    endtask

    task automatic t_clamp();
        int t, w;
        cfg_k = CW'(0); cfg_m = CW'(3); cfg_lock = PW'(30);
        w = width_of(30);
        flush();
        low_seen = 0; watch = 1'b1;
        put_sample(1'b1, t);
        put_sample(1'b1, t);
        put_sample(1'b0, t);
        put_sample(1'b0, t);
        repeat (2) @(negedge clk);
        watch = 1'b0;
        chk("R4 K=0 acts as K=M, two bad no trip", low_seen, 0);
        flush();
        put_sample(1'b1, t);
        put_sample(1'b1, t);
        put_sample(1'b1, t);
        @(negedge clk);
        chk("R4 K=0 acts as K=M, three bad trip", int'(rst_out_n), 0);
        put_sample(1'b0, t);
        put_sample(1'b0, t);
        wait_until((t - 2 * DIV) + w + 1);
        chk("R4 clamp release", int'(rst_out_n), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        rail_bad = 1'b0;
        cfg_k    = CW'(2);
        cfg_m    = CW'(3);
        cfg_div  = DW'(DIV);
        cfg_lock = PW'(30);
        @(negedge clk);
        t_power_on();
        t_sparse();
        t_cluster();
        t_retrigger();
        t_three_of_five();
        t_clamp();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule